// File: doc/BRIEF.md
# Smart Card Power-Down Sequencer

This block takes a smart card interface from its powered state to fully off in a fixed order. It is clocked by the system clock. The slow low-frequency reference, nominally 32 kHz, reaches it as a one-cycle `tick` enable in that same domain. Each step of the shutdown waits for one tick, so the card sees one slow-reference period between successive line changes.

Two events start a shutdown. The first is the card being pulled out, which the block sees as a high-to-low edge on the synchronized presence input. The second is a request pulse from the processor. Once started, the block drives four lines low, one per tick: the card reset line first, then the card clock gate, then the transmit line, and the supply enable last. It raises `busy` for the whole run and pulses `done` when the supply enable drops.

An activation-complete input puts all four lines at their active (high) levels. This lets a surrounding controller or a testbench begin from a powered card.

Top module: `sc_deact_seq`

## Requirements
- R1: While reset is asserted and after it is released, `card_rst`, `card_clk_en`, `card_tx`, `card_vcc_en`, `busy` and `done` are all 0.
- R2: A cycle with `act_done` high while idle, with no trigger in that cycle, sets all four line outputs to 1 at the next clock edge. `busy` stays 0.
- R3: A `pd_req` pulse while idle sets `busy` to 1 at the next clock edge and leaves the four line outputs unchanged.
- R4: A line output changes only at an edge where `tick` is 1 and `busy` was already 1. Each such tick drops exactly one line. A tick in the same cycle as the trigger does not advance the sequence.
- R5: The lines drop in this order, one per qualifying tick: `card_rst` first, then `card_clk_en`, then `card_tx`, and `card_vcc_en` last.
- R6: While `busy` is 1, `pd_req`, a card removal and `act_done` have no effect on the outputs.
- R7: At the edge where `card_vcc_en` drops, `busy` returns to 0 and `done` goes to 1. `done` stays 1 for exactly one cycle.
- R8: `card_present` passes through a two-stage synchronizer. A 1-to-0 change sampled at an edge sets `busy` at the third edge after it. A 0-to-1 change (insertion) starts nothing.
- R9: A shutdown triggered while the lines are already low still takes four qualifying ticks and ends with a `done` pulse.
- R10: If a trigger and `act_done` arrive together while idle, the shutdown starts and the activation is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable, once per slow reference period |
| card_present | input | 1 | Asynchronous card presence, 1 = card inserted |
| pd_req | input | 1 | Processor power-down request pulse |
| act_done | input | 1 | Activation complete: raise all four lines |
| card_rst | output | 1 | Card reset line control |
| card_clk_en | output | 1 | Card clock gate control |
| card_tx | output | 1 | Card transmit line control |
| card_vcc_en | output | 1 | Card supply enable |
| busy | output | 1 | Shutdown sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The first sequence uses a software request with idle cycles between ticks. This separates stepping on ticks from stepping on clock cycles. In that run, requests and activations are injected mid-sequence to show they are ignored. A removal-triggered run places ticks right at the synchronizer boundary and on the trigger cycle itself, which pins down the three-edge detection latency and the rule that the trigger cycle's tick does not count. A card insertion, a shutdown from an already-low state and a simultaneous request plus activation separate edge polarity, the full-length run from low, and the start-over-activation priority.

// File: rtl/sc_deact_seq.sv
module sc_deact_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_LINES   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic card_present,
  input  logic pd_req,
  input  logic act_done,
  output logic card_rst,
  output logic card_clk_en,
  output logic card_tx,
  output logic card_vcc_en,
  output logic busy,
  output logic done
);
  localparam int SW = $clog2(NUM_LINES);
  localparam logic [SW-1:0] LAST = SW'(NUM_LINES - 1);

  logic [SYNC_STAGES-1:0] pres_sync;
  logic                   pres_q;
  logic [NUM_LINES-1:0]   lines;
  logic [SW-1:0]          step;
  logic                   removal, start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pres_sync <= '0;
    else        pres_sync <= {pres_sync[SYNC_STAGES-2:0], card_present};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pres_q <= 1'b0;
    else        pres_q <= pres_sync[SYNC_STAGES-1];

  assign removal = pres_q & ~pres_sync[SYNC_STAGES-1];
  assign start   = (removal | pd_req) & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines <= '0;
      step  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy && tick) begin
        lines[step] <= 1'b0;
        step        <= step + 1'b1;
        if (step == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (act_done && !busy) begin
        lines <= '1;
      end
    end
  end

  assign card_rst    = lines[0];
  assign card_clk_en = lines[1];
  assign card_tx     = lines[2];
  assign card_vcc_en = lines[NUM_LINES-1];
endmodule

module sc_deact_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic card_rst,
  input logic card_clk_en,
  input logic card_tx,
  input logic card_vcc_en,
  input logic busy,
  input logic done
);
  a_r5_clk_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk_en) |-> !card_rst);
  a_r5_tx_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_tx) |-> !card_clk_en);
  a_r5_vcc_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_vcc_en) |-> !card_tx);
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable({card_rst, card_clk_en, card_tx, card_vcc_en}));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !card_vcc_en));
  a_r6_busy_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$rose(card_rst));
endmodule

bind sc_deact_seq sc_deact_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .card_rst(card_rst), .card_clk_en(card_clk_en), .card_tx(card_tx),
  .card_vcc_en(card_vcc_en), .busy(busy), .done(done)
);

// File: tb/sc_deact_seq_bench.sv
module sc_deact_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, card_present = 1'b1, pd_req = 1'b0, act_done = 1'b0;
  logic card_rst, card_clk_en, card_tx, card_vcc_en, busy, done;

  logic [5:0] exp_q[$];
  string      tag_q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sc_deact_seq u_sc_deact_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .card_present(card_present),
    .pd_req(pd_req), .act_done(act_done),
    .card_rst(card_rst), .card_clk_en(card_clk_en), .card_tx(card_tx),
    .card_vcc_en(card_vcc_en), .busy(busy), .done(done)
  );

  // expected vector: {card_rst, card_clk_en, card_tx, card_vcc_en, busy, done}
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [5:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {card_rst, card_clk_en, card_tx, card_vcc_en, busy, done};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual %b expected %b", t, a, e);
      end
    end
  end

  task automatic cyc(input logic tk, input logic pr, input logic ad,
                     input logic pres, input logic [5:0] e, input string tag);
    @(negedge clk);
    tick = tk; pd_req = pr; act_done = ad; card_present = pres;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state; R8 insertion edge after reset starts nothing
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 6'b000000, "R1/R8 reset idle");
    cyc(0, 0, 1, 1, 6'b111100, "R2 activate");
    cyc(0, 0, 0, 1, 6'b111100, "R2 hold");
    cyc(0, 1, 0, 1, 6'b111110, "R3 request busy");
    cyc(0, 0, 0, 1, 6'b111110, "R4 no tick hold");
    cyc(0, 0, 0, 1, 6'b111110, "R4 no tick hold");
    cyc(1, 0, 0, 1, 6'b011110, "R5 reset line first");
    cyc(0, 1, 1, 1, 6'b011110, "R6 request and activate ignored");
    cyc(1, 0, 0, 1, 6'b001110, "R5 clock gate second");
    cyc(1, 0, 0, 1, 6'b000110, "R5 transmit third");
    cyc(0, 0, 0, 1, 6'b000110, "R4 no tick hold");
    cyc(1, 0, 0, 1, 6'b000001, "R7 supply last with done");
    cyc(0, 0, 0, 1, 6'b000000, "R7 done one cycle");
    // removal path
    cyc(0, 0, 1, 1, 6'b111100, "R2 activate again");
    cyc(0, 0, 0, 0, 6'b111100, "R8 removal sync stage 1");
    cyc(1, 0, 0, 0, 6'b111100, "R8 removal sync stage 2");
    cyc(1, 0, 0, 0, 6'b111110, "R8/R4 busy on third edge, trigger tick no step");
    cyc(1, 0, 0, 0, 6'b011110, "R5 reset line first");
    cyc(1, 0, 0, 0, 6'b001110, "R5 clock gate second");
    cyc(1, 0, 0, 0, 6'b000110, "R5 transmit third");
    cyc(1, 0, 0, 0, 6'b000001, "R7 supply last with done");
    cyc(0, 0, 0, 0, 6'b000000, "R7 done one cycle");
    // insertion does not trigger
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 6'b000000, "R8 insertion ignored");
    // simultaneous trigger and activation from a low state
    cyc(0, 1, 1, 1, 6'b000010, "R10 start wins over activate");
    cyc(1, 0, 0, 1, 6'b000010, "R9 step 1 from low");
    cyc(1, 0, 0, 1, 6'b000010, "R9 step 2 from low");
    cyc(1, 0, 0, 1, 6'b000010, "R9 step 3 from low");
    cyc(1, 0, 0, 1, 6'b000001, "R9 done after four ticks");
    cyc(0, 0, 0, 1, 6'b000000, "R9 back to idle");
    cyc(0, 0, 1, 1, 6'b111100, "R2 activate after sequence");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule